// File: doc/BRIEF.md
# Audio Port Event Status and Interrupt Aggregator

This block collects per-port event pulses from the audio buffer logic into five event classes. Each class has one status bit per port. A set bit stays set until software clears it. Every class has its own mask. Each class then rolls up into one bit of a top-level status word. That word has its own clear and mask controls, and it drives a single interrupt line.

The five classes are:

| Class | Event | Direction |
|-------|-------|-----------|
| 0 | output FIFO underflow | output |
| 1 | ring-buffer underflow | output |
| 2 | ring-buffer overflow | input |
| 3 | free-mark reached | output |
| 4 | full-mark reached | input |

Output classes have one bit per output port. The highest output port is the digital-audio output. Input classes have one bit per input port.

Status bits keep latching even while their mask bit is set. The interrupt handler therefore sees the real history, and it uses the mask to decide what to service. A mask bit is changed through two separate write-one registers: one sets it and one clears it. Two software paths can therefore change masks without a read-modify-write.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset every status bit reads 0. Every implemented mask bit reads 1. `irq_o` is 0.
- R2: A 1 on `evt_i[c][n]` sets status bit n of class c at the next clock edge, whether or not that bit is masked. Classes 0, 1 and 3 implement OUT_PORTS bits. Classes 2 and 4 implement IN_PORTS bits. Event bits at or above a class's port count are ignored and read back as 0.
- R3: A write to a clear register clears each status bit whose data bit is 1. Bits written 0 keep their value.
- R4: A write to mask-set sets each mask bit written 1. A write to mask-clear clears each mask bit written 1. Zero data bits change nothing. The mask register reads back the current mask.
- R5: If an event and a clear of the same status bit happen in the same cycle, the bit stays set.
- R6: Top-level bit k is set at the edge after class k has any status bit set whose mask bit is 0. It is therefore set two edges after the event. Once set, it stays set until cleared. A top-level clear while class k is still requesting leaves the bit set.
- R7: The top-level word has its own clear, mask-set, mask-clear and mask-read registers. They follow the rules of R3 and R4. Its mask bits reset to 1.
- R8: `irq_o` is high exactly when some top-level status bit is set and its top-level mask bit is 0. Masking that bit drops `irq_o` without clearing the bit.
- R9: The register map works as follows.
  - `addr_i[5:3]` selects the bank: 0 to 4 are the classes and 5 is the top level.
  - `addr_i[2:0]` selects the function: 0 reads status, 1 clears, 2 reads the mask, 3 sets mask bits, 4 clears mask bits.
  - Reading any other address returns 0. Writes to any other address, including the read-only functions 0 and 2, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address, as bank and function |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| evt_i | input | 5 x max(OUT_PORTS, IN_PORTS) | Event pulses, indexed as [class][port] |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
The bench uses the default build: four output ports, three input ports and 32-bit data. This small configuration lets every class be swept against every event lane. The sweep includes the unimplemented fourth lane of the input classes, so R2 is checked in all 20 class/port combinations. Each mask function is exercised on all six banks. The roll-up from each of the five classes is checked one edge at a time: the one-cycle latency, re-latching under a top-level clear, and masking at the top level. Expected words come from port-count arithmetic in the bench.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned NUM_CLASS = 5;
  localparam int unsigned NUM_BANK  = NUM_CLASS + 1;
  localparam int unsigned BANK_W    = 3;
  localparam int unsigned FN_W      = 3;
  localparam int unsigned ADDR_W    = BANK_W + FN_W;

  typedef enum logic [FN_W-1:0] {
    FN_STAT = 3'd0,
    FN_CLR  = 3'd1,
    FN_MASK = 3'd2,
    FN_MSET = 3'd3,
    FN_MCLR = 3'd4
  } fn_e;

  // classes 2 and 4 are input-direction, the rest output-direction
  function automatic bit class_is_input(int unsigned c);
    return (c == 2) || (c == 4);
  endfunction
endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode #(
  parameter int unsigned NB = evt_pkg::NUM_BANK
) (
  input  logic                        wr_i,
  input  logic [evt_pkg::ADDR_W-1:0]  addr_i,
  output logic [NB-1:0]               clr_we_o,
  output logic [NB-1:0]               mset_we_o,
  output logic [NB-1:0]               mclr_we_o,
  output logic [evt_pkg::BANK_W-1:0]  bank_o,
  output logic                        bank_ok_o,
  output evt_pkg::fn_e                fn_o
);
  import evt_pkg::*;

  assign bank_o    = addr_i[ADDR_W-1:FN_W];
  assign fn_o      = fn_e'(addr_i[FN_W-1:0]);
  assign bank_ok_o = (32'(bank_o) < NB);

  for (genvar b = 0; b < NB; b++) begin : g_we
    logic hit;
    assign hit          = wr_i && (bank_o == BANK_W'(b));
    assign clr_we_o[b]  = hit && (fn_o == FN_CLR);
    assign mset_we_o[b] = hit && (fn_o == FN_MSET);
    assign mclr_we_o[b] = hit && (fn_o == FN_MCLR);
  end
endmodule

// File: rtl/evt_stat_bank.sv
module evt_stat_bank #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic         mset_we_i,
  input  logic         mclr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         req_o
);
  logic [W-1:0] status_q, mask_q, clr_bits;

  assign clr_bits = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      // event applied after clear: event wins
      status_q <= (status_q & ~clr_bits) | evt_i;
      if (mset_we_i)      mask_q <= mask_q | wdata_i;
      else if (mclr_we_i) mask_q <= mask_q & ~wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign req_o    = |(status_q & ~mask_q);

  p_evt_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
  p_evt_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && ((evt_i & wdata_i) != '0)) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((status_q & $past(status_q)) == $past(status_q)));
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((status_q & $past(wdata_i & ~evt_i)) == '0));
  p_mask_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mset_we_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  p_mask_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mclr_we_i && !mset_we_i) |=> ((mask_q & $past(wdata_i)) == '0));
  p_mask_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mset_we_i && !mclr_we_i) |=> $stable(mask_q));
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg #(
  parameter int unsigned OUT_PORTS = 4,
  parameter int unsigned IN_PORTS  = 3,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned MaxPorts = (OUT_PORTS > IN_PORTS) ? OUT_PORTS : IN_PORTS
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        wr_i,
  input  logic [evt_pkg::ADDR_W-1:0]                  addr_i,
  input  logic [DATA_W-1:0]                           wdata_i,
  output logic [DATA_W-1:0]                           rdata_o,
  input  logic [evt_pkg::NUM_CLASS-1:0][MaxPorts-1:0] evt_i,
  output logic                                        irq_o
);
  import evt_pkg::*;

  localparam int unsigned WMax = (MaxPorts > NUM_CLASS) ? MaxPorts : NUM_CLASS;

  logic [NUM_BANK-1:0]             clr_we, mset_we, mclr_we;
  logic [BANK_W-1:0]               bank;
  logic                            bank_ok;
  fn_e                             fn;
  logic [NUM_BANK-1:0][DATA_W-1:0] stat_pad, mask_pad;
  logic [NUM_CLASS-1:0]            cls_req, top_stat, top_mask;
  logic                            top_req;
  logic [NUM_CLASS-1:0]            evt_pad_unused;
  logic                            wdata_unused;

  evt_reg_decode #(.NB(NUM_BANK)) u_dec (
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .clr_we_o  (clr_we),
    .mset_we_o (mset_we),
    .mclr_we_o (mclr_we),
    .bank_o    (bank),
    .bank_ok_o (bank_ok),
    .fn_o      (fn)
  );

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    localparam int unsigned W = class_is_input(c) ? IN_PORTS : OUT_PORTS;
    logic [W-1:0] st, mk;

    evt_stat_bank #(.W(W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i[c][W-1:0]),
      .clr_we_i  (clr_we[c]),
      .mset_we_i (mset_we[c]),
      .mclr_we_i (mclr_we[c]),
      .wdata_i   (wdata_i[W-1:0]),
      .status_o  (st),
      .mask_o    (mk),
      .req_o     (cls_req[c])
    );

    assign stat_pad[c] = {{(DATA_W-W){1'b0}}, st};
    assign mask_pad[c] = {{(DATA_W-W){1'b0}}, mk};

    if (W < MaxPorts) begin : g_pad
      assign evt_pad_unused[c] = |evt_i[c][MaxPorts-1:W];
    end else begin : g_full
      assign evt_pad_unused[c] = 1'b0;
    end
  end

  evt_stat_bank #(.W(NUM_CLASS)) u_top (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (cls_req),
    .clr_we_i  (clr_we[NUM_CLASS]),
    .mset_we_i (mset_we[NUM_CLASS]),
    .mclr_we_i (mclr_we[NUM_CLASS]),
    .wdata_i   (wdata_i[NUM_CLASS-1:0]),
    .status_o  (top_stat),
    .mask_o    (top_mask),
    .req_o     (top_req)
  );

  assign stat_pad[NUM_CLASS] = {{(DATA_W-NUM_CLASS){1'b0}}, top_stat};
  assign mask_pad[NUM_CLASS] = {{(DATA_W-NUM_CLASS){1'b0}}, top_mask};
  assign irq_o        = top_req;
  assign wdata_unused = |wdata_i[DATA_W-1:WMax];

  always_comb begin
    rdata_o = '0;
    if (bank_ok) begin
      case (fn)
        FN_STAT: rdata_o = stat_pad[bank];
        FN_MASK: rdata_o = mask_pad[bank];
        default: rdata_o = '0;
      endcase
    end
  end

  p_roll_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cls_req & ~top_mask) != '0) && !mset_we[NUM_CLASS]) |=> irq_o);
  p_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_mask == '1) |-> !irq_o);
  p_one_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clr_we, mset_we, mclr_we}));
endmodule

// File: tb/sim_evt_irq_agg.sv
`timescale 1ns/1ps
module sim_evt_irq_agg;
  logic             clk = 1'b0;
  logic             rst_ni;
  logic             wr_i;
  logic [5:0]       addr_i;
  logic [31:0]      wdata_i;
  logic [31:0]      rdata_o;
  logic [4:0][3:0]  evt_i;
  logic             irq_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  evt_irq_agg u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i), .irq_o(irq_o)
  );

  function automatic int nports(int b);
    if (b == 5) return 5;
    return (b == 2 || b == 4) ? 3 : 4;
  endfunction

  function automatic logic [31:0] full(int b);
    return (32'd1 << nports(b)) - 32'd1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(int b, int f, output logic [31:0] d);
    addr_i = {b[2:0], f[2:0]};
    #1 d = rdata_o;
  endtask

  task automatic wr(int b, int f, logic [31:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = {b[2:0], f[2:0]}; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic pulse(int c, logic [3:0] bits);
    @(negedge clk);
    evt_i[c] = bits;
    @(negedge clk);
    evt_i[c] = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_ni = 1'b0; wr_i = 1'b0; addr_i = '0; wdata_i = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int b = 0; b < 6; b++) begin
      rd(b, 0, d); chk("R1 status", d, 0);
      rd(b, 2, d); chk("R1 mask", d, full(b));
    end
    chk("R1 irq", {31'd0, irq_o}, 0);

    // R2 sweep every lane while masked, R3 full clear
    for (int c = 0; c < 5; c++) begin
      for (int p = 0; p < 4; p++) begin
        pulse(c, 4'(1 << p));
        rd(c, 0, d);
        chk("R2 latch", d, (p < nports(c)) ? (32'd1 << p) : 32'd0);
        rd(5, 0, d); chk("R6 masked class", d, 0);
        wr(c, 1, 32'hFFFF_FFFF);
        rd(c, 0, d); chk("R3 clear all", d, 0);
      end
    end

    // R3 partial clear and zero write
    for (int c = 0; c < 5; c++) begin
      pulse(c, 4'hF);
      wr(c, 1, 32'h5);
      rd(c, 0, d); chk("R3 partial", d, full(c) & 32'hA);
      wr(c, 1, 32'h0);
      rd(c, 0, d); chk("R3 zero write", d, full(c) & 32'hA);
      wr(c, 1, 32'hFFFF_FFFF);
    end

    // R4 / R7 mask set and clear on all banks
    for (int b = 0; b < 6; b++) begin
      string tag;
      tag = (b == 5) ? "R7 mask" : "R4 mask";
      wr(b, 4, 32'h3);
      rd(b, 2, d); chk(tag, d, full(b) & ~32'h3);
      wr(b, 3, 32'h1);
      rd(b, 2, d); chk(tag, d, full(b) & ~32'h2);
      wr(b, 3, 32'h0);
      rd(b, 2, d); chk(tag, d, full(b) & ~32'h2);
      wr(b, 4, 32'h0);
      rd(b, 2, d); chk(tag, d, full(b) & ~32'h2);
      wr(b, 3, 32'hFFFF_FFFF);
      rd(b, 2, d); chk(tag, d, full(b));
    end

    // R5 event and clear in the same cycle
    pulse(1, 4'b0101);
    @(negedge clk);
    evt_i[1] = 4'b0100; wr_i = 1'b1; addr_i = {3'd1, 3'd1}; wdata_i = 32'hF;
    @(negedge clk);
    evt_i[1] = '0; wr_i = 1'b0; wdata_i = '0;
    rd(1, 0, d); chk("R5 event wins", d, 32'h4);
    wr(1, 1, 32'hF);

    // R6 / R7 / R8 roll-up per class
    for (int c = 0; c < 5; c++) begin
      wr(c, 4, 32'h1);
      wr(5, 4, 32'd1 << c);
      pulse(c, 4'h1);
      rd(5, 0, d); chk("R6 latency", d, 0);
      chk("R8 irq low", {31'd0, irq_o}, 0);
      @(negedge clk);
      rd(5, 0, d); chk("R6 rollup", d, 32'd1 << c);
      chk("R8 irq high", {31'd0, irq_o}, 1);
      wr(5, 1, 32'd1 << c);
      rd(5, 0, d); chk("R6 relatch", d, 32'd1 << c);
      wr(c, 1, 32'h1);
      rd(5, 0, d); chk("R6 sticky", d, 32'd1 << c);
      chk("R8 irq sticky", {31'd0, irq_o}, 1);
      wr(5, 1, 32'd1 << c);
      rd(5, 0, d); chk("R7 top clear", d, 0);
      chk("R8 irq cleared", {31'd0, irq_o}, 0);
      pulse(c, 4'h1);
      @(negedge clk);
      wr(5, 3, 32'd1 << c);
      chk("R8 top masked", {31'd0, irq_o}, 0);
      rd(5, 0, d); chk("R8 status kept", d, 32'd1 << c);
      wr(c, 1, 32'hF);
      wr(5, 1, 32'h1F);
      rd(5, 0, d); chk("R7 cleanup", d, 0);
      wr(c, 3, 32'hF);
    end

    // R9 unused addresses
    for (int f = 5; f < 8; f++) begin
      rd(0, f, d); chk("R9 unused fn read", d, 0);
    end
    rd(6, 0, d); chk("R9 bank 6 read", d, 0);
    rd(7, 2, d); chk("R9 bank 7 read", d, 0);
    pulse(0, 4'h3);
    wr(0, 0, 32'hFFFF_FFFF);
    rd(0, 0, d); chk("R9 write to status ignored", d, 32'h3);
    wr(0, 2, 32'h0);
    rd(0, 2, d); chk("R9 write to mask read ignored", d, 32'hF);
    wr(6, 1, 32'hFFFF_FFFF);
    rd(0, 0, d); chk("R9 bank 6 write ignored", d, 32'h3);
    wr(0, 5, 32'hFFFF_FFFF);
    rd(0, 0, d); chk("R9 fn 5 write ignored", d, 32'h3);
    wr(0, 1, 32'hF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule